// File: doc/BRIEF.md
# Passive Configuration Stream Sequencer

This block loads a configuration bitstream into an FPGA target that takes it passively over a clock and data pins. A one-cycle `start` pulse, together with a byte count and a transfer mode, opens a session. The block drives the target's active-low configuration-reset pin low for a timed pulse and then waits for a setup interval. After that it takes bytes one at a time over a valid/ready handshake. Each byte goes out on the data pins with one or more configuration clock pulses. The data only changes while the configuration clock is low.

Three transfer modes are supported. In one-bit serial mode a byte leaves least-significant bit first on bit 0, one clock pulse per bit. In byte-wide mode the whole byte goes out with a single pulse. In byte-wide secure mode the byte is held for four pulses so that the target can decrypt it. Before each byte the target's active-low status pin is checked. After the final byte, one trailing rising clock edge is issued. After a settling wait the target's configuration-complete pin is sampled.

The result is reported on `done` or `error`, and each stays set until the next start. Every failed session produces a one-cycle `abort` pulse. `sent_count` gives the number of bytes fully clocked out.

Top module: `cfg_stream_seq`

## Requirements
- R1: An accepted start drives `fpga_ncfg` low for exactly CYC_PER_US*max(PULSE_US,2) system clocks and then releases it high. `busy` is high for the whole session.
- R2: After `fpga_ncfg` rises, no rising edge of `fpga_dclk` occurs for at least CYC_PER_US*WAIT_US system clocks.
- R3: `fpga_dclk` is low while idle. `fpga_data` never changes while `fpga_dclk` is high. Each clock phase lasts at least max(PHASE_CLKS,1) system clocks.
- R4: With mode 2'b00 (serial), each byte gives 8 rising edges. On the n-th edge `fpga_data` is {7'b0, byte[n]}, taken from bit 0 upward.
- R5: With mode 2'b01 (byte-wide), each byte gives exactly one rising edge, with the full byte on `fpga_data`.
- R6: With mode 2'b10 (secure byte-wide), each byte gives exactly four rising edges, with the same full byte on `fpga_data` at all four.
- R7: `in_ready` is high only while the block waits for the next byte with `fpga_nstatus` high. Exactly one byte is consumed per handshake, and `in_ready` drops in the cycle after a handshake.
- R8: If `fpga_nstatus` is low when the next byte is due, the session ends. `error` is set, `abort` pulses, no further byte is accepted even if offered in that same cycle, and `sent_count` equals the bytes completed.
- R9: After the last byte, exactly one extra rising edge of `fpga_dclk` is issued. `fpga_confdone` is sampled CYC_PER_US*DONE_US clocks after it. If the pin is high, `done` is set and `busy` falls at that point.
- R10: If `fpga_confdone` is low at that sample, `error` is set and `abort` pulses once.
- R11: A start with a byte count of zero, or with mode 2'b11, sets `error` and pulses `abort` in the next cycle, without any `fpga_ncfg` low pulse.
- R12: After any session the block is idle with `fpga_ncfg` high, `fpga_dclk` low and `busy` low. `done` and `error` keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a session (ignored while busy) |
| mode | input | 2 | Transfer mode: 00 serial, 01 byte-wide, 10 secure byte-wide, 11 invalid |
| byte_count | input | CNT_W | Number of bytes in the session, latched at start |
| in_data | input | 8 | Next stream byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| fpga_ncfg | output | 1 | Active-low configuration reset to the target |
| fpga_dclk | output | 1 | Configuration clock to the target |
| fpga_data | output | 8 | Configuration data; only bit 0 used in serial mode |
| fpga_nstatus | input | 1 | Active-low target status, high means healthy |
| fpga_confdone | input | 1 | Target reports configuration complete |
| busy | output | 1 | Session in progress |
| done | output | 1 | Last session succeeded |
| error | output | 1 | Last session or start request failed |
| abort | output | 1 | One-cycle pulse on any failure |
| sent_count | output | CNT_W | Bytes fully clocked out in the last session |

## Verification
The status check and the byte handshake share the same wait state, so a status fault and a byte offer can land in the same cycle. The bench provokes this by pulling `fpga_nstatus` low right after a byte is taken and offering the next byte with `in_valid` held high until the session ends. The fault must win: `sent_count` must equal the bytes already finished, and `abort` must pulse once. No further configuration clock edge may appear, which the scoreboard would report as an unexpected edge. This is run both mid-stream and with the status pin low before the first byte.

// File: rtl/cfg_seq_pkg.sv
// Package: shared types for the passive configuration stream sequencer.
// Holds the mode encoding, the controller state encoding and the
// per-byte clock pulse count for each mode.
package cfg_seq_pkg;

    localparam int BITS_PER_BYTE = 8;
    localparam int SECURE_EXTRA  = 3;

    typedef enum logic [1:0] {
        MODE_SERIAL = 2'b00,
        MODE_BYTE   = 2'b01,
        MODE_SECURE = 2'b10,
        MODE_BAD    = 2'b11
    } cfg_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CFG_LOW,
        S_CFG_WAIT,
        S_FETCH,
        S_CLK_LO,
        S_CLK_HI,
        S_TRAIL_LO,
        S_DONE_WAIT
    } cfg_state_e;

    // Number of rising clock edges one byte needs in the given mode
    function automatic logic [3:0] pulses_for(input cfg_mode_e m);
        case (m)
            MODE_SERIAL: return 4'(BITS_PER_BYTE);
            MODE_SECURE: return 4'(1 + SECURE_EXTRA);
            default:     return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
// Module: cfg_seq_timer
// Down-counting interval timer shared by every timed phase of a session.
// Assumes: load is given once on entry to a phase; expire rises in the
// last cycle of an interval of exactly load_val cycles (load_val >= 1).
module cfg_seq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);

    logic [TW-1:0] cnt;

    // Count down from the loaded value and stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Last cycle of the interval
    assign expire = (cnt == TW'(1));

endmodule

// File: rtl/cfg_seq_serializer.sv
// Module: cfg_seq_serializer
// Holds the byte being sent, presents it on the data bus for the chosen
// mode and counts the clock pulses still owed for that byte.
// Assumes: load and advance are never high in the same cycle; advance
// is given once per completed high phase.
module cfg_seq_serializer
    import cfg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  cfg_mode_e  mode_in,
    input  logic       advance,
    output logic [7:0] bus,
    output logic       last_pulse
);

    logic [7:0] shreg;
    logic [3:0] left;
    logic       serial_q;

    // Latch the byte, then step bits (serial) and the pulse budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            left     <= '0;
            serial_q <= 1'b0;
        end else if (load) begin
            shreg    <= byte_in;
            left     <= pulses_for(mode_in);
            serial_q <= (mode_in == MODE_SERIAL);
        end else if (advance && left != 4'd0) begin
            left <= left - 4'd1;
            if (serial_q) begin
                shreg <= {1'b0, shreg[7:1]};
            end
        end
    end

    // Serial mode drives bit 0 only; byte modes drive the whole byte
    assign bus        = serial_q ? {7'b0, shreg[0]} : shreg;
    assign last_pulse = (left == 4'd1);

endmodule

// File: rtl/cfg_stream_seq.sv
// Module: cfg_stream_seq (top)
// Sequences a passive FPGA configuration session: timed reset pulse,
// setup wait, per-byte status check and clocking, trailing edge and
// completion sample. All delays are counted in system clocks.
// Assumes: fpga_nstatus and fpga_confdone are already synchronous to
// clk; start is a single-cycle request and is ignored while busy.
module cfg_stream_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_US   = 5,
    parameter int WAIT_US    = 100,
    parameter int DONE_US    = 100,
    parameter int PHASE_CLKS = 2,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             fpga_ncfg,
    output logic             fpga_dclk,
    output logic [7:0]       fpga_data,
    input  logic             fpga_nstatus,
    input  logic             fpga_confdone,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             abort,
    output logic [CNT_W-1:0] sent_count
);

    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int PULSE_EFF  = (PULSE_US < 2) ? 2 : PULSE_US;
    localparam int PULSE_CYC  = CYC_PER_US * PULSE_EFF;
    localparam int WAIT_CYC   = (WAIT_US < 1) ? 1 : CYC_PER_US * WAIT_US;
    localparam int DONE_CYC   = (DONE_US < 1) ? 1 : CYC_PER_US * DONE_US;
    localparam int PHASE_CYC  = (PHASE_CLKS < 1) ? 1 : PHASE_CLKS;
    localparam int MAX_A      = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
    localparam int MAX_B      = (DONE_CYC > PHASE_CYC) ? DONE_CYC : PHASE_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW         = $clog2(MAX_CYC + 1);

    cfg_state_e       state;
    cfg_mode_e        mode_q;
    logic             ncfg_q, dclk_q, busy_q, done_q, err_q, abort_q;
    logic [CNT_W-1:0] sent_q, remain_q;

    logic             tmr_load, tmr_exp;
    logic [TW-1:0]    tmr_val;
    logic             ser_load, ser_adv, ser_last;
    logic [7:0]       ser_bus;
    logic             start_ok;

    // A start is accepted only with a non-zero count and a defined mode
    assign start_ok = (byte_count != '0) && (cfg_mode_e'(mode) != MODE_BAD);

    // Handshake open only while waiting for a byte with healthy status
    assign in_ready = (state == S_FETCH) && fpga_nstatus;

    cfg_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    cfg_seq_serializer u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ser_load),
        .byte_in    (in_data),
        .mode_in    (mode_q),
        .advance    (ser_adv),
        .bus        (ser_bus),
        .last_pulse (ser_last)
    );

    // Timer reloads and serializer strobes for the next phase
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        ser_load = 1'b0;
        ser_adv  = 1'b0;
        case (state)
            S_IDLE: begin
                if (start && start_ok) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC);
                end
            end
            S_CFG_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAIT_CYC);
                end
            end
            S_FETCH: begin
                if (fpga_nstatus && in_valid) begin
                    ser_load = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PHASE_CYC);
                end
            end
            S_CLK_LO: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PHASE_CYC);
                end
            end
            S_CLK_HI: begin
                if (tmr_exp) begin
                    ser_adv = 1'b1;
                    if (!ser_last || remain_q == CNT_W'(1)) begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(PHASE_CYC);
                    end
                end
            end
            S_TRAIL_LO: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DONE_CYC);
                end
            end
            default: ;
        endcase
    end

    // Session controller: pins, result flags and byte bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            mode_q   <= MODE_SERIAL;
            ncfg_q   <= 1'b1;
            dclk_q   <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            abort_q  <= 1'b0;
            sent_q   <= '0;
            remain_q <= '0;
        end else begin
            abort_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        if (start_ok) begin
                            state    <= S_CFG_LOW;
                            ncfg_q   <= 1'b0;
                            busy_q   <= 1'b1;
                            err_q    <= 1'b0;
                            sent_q   <= '0;
                            remain_q <= byte_count;
                            mode_q   <= cfg_mode_e'(mode);
                        end else begin
                            err_q   <= 1'b1;
                            abort_q <= 1'b1;
                        end
                    end
                end
                S_CFG_LOW: begin
                    if (tmr_exp) begin
                        ncfg_q <= 1'b1;
                        state  <= S_CFG_WAIT;
                    end
                end
                S_CFG_WAIT: begin
                    if (tmr_exp) begin
                        state <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (!fpga_nstatus) begin
                        err_q   <= 1'b1;
                        abort_q <= 1'b1;
                        busy_q  <= 1'b0;
                        state   <= S_IDLE;
                    end else if (in_valid) begin
                        state <= S_CLK_LO;
                    end
                end
                S_CLK_LO: begin
                    if (tmr_exp) begin
                        dclk_q <= 1'b1;
                        state  <= S_CLK_HI;
                    end
                end
                S_CLK_HI: begin
                    if (tmr_exp) begin
                        dclk_q <= 1'b0;
                        if (ser_last) begin
                            sent_q   <= sent_q + 1'b1;
                            remain_q <= remain_q - 1'b1;
                            state    <= (remain_q == CNT_W'(1)) ? S_TRAIL_LO : S_FETCH;
                        end else begin
                            state <= S_CLK_LO;
                        end
                    end
                end
                S_TRAIL_LO: begin
                    if (tmr_exp) begin
                        dclk_q <= 1'b1;
                        state  <= S_DONE_WAIT;
                    end
                end
                S_DONE_WAIT: begin
                    if (tmr_exp) begin
                        dclk_q <= 1'b0;
                        busy_q <= 1'b0;
                        state  <= S_IDLE;
                        if (fpga_confdone) begin
                            done_q <= 1'b1;
                        end else begin
                            err_q   <= 1'b1;
                            abort_q <= 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign fpga_ncfg  = ncfg_q;
    assign fpga_dclk  = dclk_q;
    assign fpga_data  = ser_bus;
    assign busy       = busy_q;
    assign done       = done_q;
    assign error      = err_q;
    assign abort      = abort_q;
    assign sent_count = sent_q;

endmodule

// File: rtl/cfg_stream_seq_checker.sv
// Module: cfg_stream_seq_checker
// Protocol properties of the sequencer, observed at its ports only.
// Assumes: bound to cfg_stream_seq through the bind statement below.
module cfg_stream_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       fpga_ncfg,
    input logic       fpga_dclk,
    input logic [7:0] fpga_data,
    input logic       fpga_nstatus,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       abort
);

    // R1: reset pulse only inside a session, and never with the clock high
    p_cfg_low_in_session_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fpga_ncfg |-> (busy && !fpga_dclk));

    // R3: data held while the configuration clock is high
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fpga_dclk |-> $stable(fpga_data));

    // R7: handshake only while waiting, released and healthy
    p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && fpga_ncfg && !fpga_dclk && fpga_nstatus));

    // R8: an abort always comes with an error and an ended session
    p_abort_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (error && !busy));

    // R9: success and failure never reported together
    p_result_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R12: idle pins outside a session
    p_idle_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fpga_ncfg && !fpga_dclk));

endmodule

bind cfg_stream_seq cfg_stream_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .fpga_ncfg    (fpga_ncfg),
    .fpga_dclk    (fpga_dclk),
    .fpga_data    (fpga_data),
    .fpga_nstatus (fpga_nstatus),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .abort        (abort)
);

// File: tb/cfg_stream_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected bus value of every
// configuration clock edge; a monitor pops and compares on each edge.
module cfg_stream_seq_bench;

    localparam int CLK_HZ    = 50_000_000;
    localparam int PULSE_US  = 5;
    localparam int WAIT_US   = 10;
    localparam int DONE_US   = 10;
    localparam int PHASE     = 2;
    localparam int CNT_W     = 16;
    localparam int CPU       = CLK_HZ / 1_000_000;
    localparam int PULSE_CYC = CPU * PULSE_US;
    localparam int WAIT_CYC  = CPU * WAIT_US;
    localparam int DONE_CYC  = CPU * DONE_US;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             fpga_ncfg, fpga_dclk;
    logic [7:0]       fpga_data;
    logic             fpga_nstatus = 1'b1;
    logic             fpga_confdone = 1'b0;
    logic             busy, done, error, abort;
    logic [CNT_W-1:0] sent_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_stream_seq #(
        .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .WAIT_US(WAIT_US),
        .DONE_US(DONE_US), .PHASE_CLKS(PHASE), .CNT_W(CNT_W)
    ) u_cfg_stream_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .fpga_ncfg(fpga_ncfg), .fpga_dclk(fpga_dclk),
        .fpga_data(fpga_data), .fpga_nstatus(fpga_nstatus),
        .fpga_confdone(fpga_confdone), .busy(busy), .done(done),
        .error(error), .abort(abort), .sent_count(sent_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard state shared by driver and monitor
    logic [7:0] exp_q[$];
    string      edge_req = "R4";
    int         trail_edges = 0, low_cnt = 0, gap_cnt = 0, first_gap = -1;
    int         tail_cnt = 0, abort_cnt = 0;
    bit         gap_run = 0;
    logic       prev_dclk = 1'b0, prev_ncfg = 1'b1;

    // Monitor: compare every rising clock edge, measure intervals
    always @(negedge clk) begin
        if (rst_n) begin
            if (fpga_dclk && !prev_dclk) begin
                tail_cnt = 1;
                if (gap_run) begin
                    first_gap = gap_cnt;
                    gap_run   = 0;
                end
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(fpga_data == e, {edge_req, "/R3 data at edge"}, fpga_data, e);
                end else begin
                    trail_edges++;
                end
            end else if (busy) begin
                tail_cnt++;
            end
            if (!fpga_ncfg) low_cnt++;
            if (fpga_ncfg && !prev_ncfg) begin
                gap_run = 1;
                gap_cnt = 0;
            end
            if (gap_run) gap_cnt++;
            if (abort) abort_cnt++;
        end
        prev_dclk = fpga_dclk;
        prev_ncfg = fpga_ncfg;
    end

    // Driver: one session; fail_at < 0 means status stays healthy
    task automatic run(input logic [1:0] m, input int n, input int fail_at,
                       input bit cdone, input string req);
        bit ok;
        int exp_sent;
        ok       = (fail_at < 0) && cdone;
        exp_sent = (fail_at < 0) ? n : fail_at;
        edge_req = req;
        exp_q.delete();
        low_cnt = 0; trail_edges = 0; abort_cnt = 0; first_gap = -1; gap_run = 0;
        fpga_confdone = cdone;
        fpga_nstatus  = (fail_at != 0);
        @(negedge clk);
        mode = m; byte_count = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'hA5 ^ 8'(i * 37);
            if (i == fail_at) begin
                // Collide: status fault while a byte is on offer
                fpga_nstatus = 1'b0;
                in_valid = 1'b1; in_data = v;
                while (busy) @(negedge clk);
                in_valid = 1'b0;
                break;
            end
            while (!in_ready && busy) @(negedge clk);
            in_valid = 1'b1; in_data = v;
            if (m == 2'b00) begin
                for (int b = 0; b < 8; b++) exp_q.push_back({7'b0, v[b]});
            end else if (m == 2'b01) begin
                exp_q.push_back(v);
            end else begin
                for (int k = 0; k < 4; k++) exp_q.push_back(v);
            end
            @(negedge clk);
            in_valid = 1'b0;
            chk(!in_ready, "R7 ready after handshake", in_ready, 0);
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(done == ok, ok ? "R9 done" : "R9 done low", done, ok);
        chk(error == !ok, (fail_at >= 0) ? "R8 error" : "R10 error", error, !ok);
        chk(abort_cnt == (ok ? 0 : 1), ok ? "R9 no abort" : "R10/R8 abort pulse", abort_cnt, ok ? 0 : 1);
        chk(sent_count == CNT_W'(exp_sent), "R8 sent count", sent_count, exp_sent);
        chk(exp_q.size() == 0, {req, " edges missing"}, exp_q.size(), 0);
        chk(trail_edges == ((fail_at < 0) ? 1 : 0), "R9 trailing edge", trail_edges, (fail_at < 0) ? 1 : 0);
        if (fail_at < 0)
            chk(tail_cnt == DONE_CYC, "R9 completion wait", tail_cnt, DONE_CYC);
        chk(low_cnt == PULSE_CYC, "R1 reset pulse width", low_cnt, PULSE_CYC);
        if (fail_at != 0)
            chk(first_gap >= WAIT_CYC, "R2 setup wait", first_gap, WAIT_CYC);
        chk(fpga_ncfg && !fpga_dclk && !busy, "R12 idle pins", {fpga_ncfg, fpga_dclk, busy}, 3'b100);
        repeat (8) @(negedge clk);
        chk(done == ok && error == !ok, "R12 result held", {done, error}, {ok, !ok});
        fpga_nstatus = 1'b1;
    endtask

    // Start requests that must be refused
    task automatic run_bad(input logic [1:0] m, input int n);
        low_cnt = 0; abort_cnt = 0;
        @(negedge clk);
        mode = m; byte_count = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(error && !done && !busy, "R11 rejected start", {error, done, busy}, 3'b100);
        chk(abort_cnt == 1, "R11 abort pulse", abort_cnt, 1);
        repeat (5) @(negedge clk);
        chk(low_cnt == 0 && fpga_ncfg, "R11 no reset pulse", low_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fpga_ncfg && !fpga_dclk && !busy && !done && !error && !in_ready && !abort,
            "R12 reset state", {fpga_ncfg, fpga_dclk, busy, done, error, in_ready}, 6'b100000);
        run(2'b00, 3, -1, 1'b1, "R4");
        run(2'b01, 5, -1, 1'b1, "R5");
        run(2'b10, 4, -1, 1'b1, "R6");
        run(2'b01, 2, -1, 1'b0, "R5");
        run(2'b00, 4, 2, 1'b1, "R4");
        run(2'b10, 3, 0, 1'b1, "R6");
        run_bad(2'b01, 0);
        run_bad(2'b11, 4);
        run(2'b01, 1, -1, 1'b1, "R5");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule